// File: doc/BRIEF.md
# Multi-Context Command Scheduler

This block decides which of several software threads owns a single rendering pipeline. Each thread has its own command buffer. The buffer is described by a valid flag plus a read pointer and a write pointer. The scheduler checks every descriptor on every cycle without any help from the host, and a thread has pending work when its descriptor is valid and its pointers differ. Only the owning thread may offer commands downstream. Each accepted command produces a one-cycle advance pulse that moves that thread's read pointer on.

Changing owners is a full context switch. The state words of the outgoing thread are read from the pipeline and written to memory at `thread * CTX_WORDS + word`. Then the state words of the incoming thread are read back from its own region and loaded into the pipeline. Both transfers use one request/acknowledge memory port. A switch happens only at a command boundary, in one of two cases:

- The owner's buffer has run dry and another thread has work. The next owner is then chosen round-robin.
- A priority interrupt has named a different target thread. In that case the target is taken even if the owner still has work.

A cycle budget, `SWITCH_BUDGET_CYCLES`, sets the time allowed for a switch. The default of 1500 is 15 µs at 100 MHz. If a switch runs longer than the budget, an overrun flag is raised.

Top module: `ctx_sched`

## Requirements
- R1: After reset the following outputs are all 0: `owner_valid`, `cmd_valid`, `mem_req`, `rd_adv`, `switching` and `overrun`.
- R2: A thread is pending when `desc_valid[t]=1` and its read and write pointers differ. With no owner yet, the scheduler picks the lowest-numbered pending thread by itself. It restores that thread's state and then reports it on `owner_thread` with `owner_valid=1`.
- R3: Only the owner issues commands. While `cmd_valid=1`, `cmd_thread` equals `owner_thread` and `cmd_addr` is the owner's read pointer. `rd_adv` is one-hot, bit t = thread t, and its owner bit pulses exactly in the cycles where `cmd_valid` and `cmd_ready` are both 1.
- R4: Once `cmd_valid` is raised, it stays high with `cmd_thread` and `cmd_addr` unchanged until `cmd_ready` accepts the command.
- R5: When the owner has no pending work and another thread does, the next owner is the first pending thread above the owner index, counting upward and wrapping past N-1 to 0. If no other thread is pending, the owner keeps the pipeline and no memory request is made.
- R6: Save writes CTX_WORDS words in order (`mem_we=1`). Word i is read from the pipeline at `ctx_rd_idx=i` and is written to address `owner*CTX_WORDS+i`.
- R7: Restore reads address `next*CTX_WORDS+i` (`mem_we=0`) for i ascending. Each acknowledged word is written to the pipeline at `ctx_wr_idx=i`. After the last word, `owner_thread` becomes the new thread.
- R8: While `mem_req=1` and `mem_ack=0`, the request stays high and `mem_addr` and `mem_we` hold.
- R9: `switching` is 1 throughout save and restore. `cmd_valid` is 0 whenever `switching` or `mem_req` is 1.
- R10: A pulse on `irq_req` latches `irq_thread`. If it names another thread, the command already offered completes first. The scheduler then saves the owner and restores the target, ahead of any round-robin choice and even if the owner still has work. If it names the owner, nothing happens.
- R11: `overrun` rises when a switch is still in progress after SWITCH_BUDGET_CYCLES cycles. It stays high until the next switch starts, which clears it.
- R12: A thread with `desc_valid=0` is never chosen, even when its pointers differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | N_THREADS | Descriptor valid flag per thread |
| desc_rd_ptr | input | N_THREADS*PTR_W | Read pointers, thread t at bits [t*PTR_W +: PTR_W] |
| desc_wr_ptr | input | N_THREADS*PTR_W | Write pointers, same packing |
| rd_adv | output | N_THREADS | One-cycle read-pointer advance, one-hot by thread |
| cmd_valid | output | 1 | Command offered to the pipeline |
| cmd_ready | input | 1 | Pipeline accepts the offered command |
| cmd_thread | output | TW | Thread of the offered command |
| cmd_addr | output | PTR_W | Read pointer of the offered command |
| irq_req | input | 1 | Priority switch request pulse |
| irq_thread | input | TW | Target thread of the switch request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write (save), 0 = read (restore) |
| mem_addr | output | AW | Word address in the context area |
| mem_wdata | output | 32 | Saved state word |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Restored state word, valid with ack |
| ctx_rd_idx | output | IW | Pipeline state word being saved |
| ctx_rd_data | input | 32 | Pipeline state word at ctx_rd_idx |
| ctx_wr_en | output | 1 | Load one pipeline state word |
| ctx_wr_idx | output | IW | Pipeline state word being loaded |
| ctx_wr_data | output | 32 | Value loaded into the pipeline |
| owner_valid | output | 1 | A thread owns the pipeline |
| owner_thread | output | TW | Current owner |
| switching | output | 1 | Save or restore in progress |
| overrun | output | 1 | Last switch exceeded the cycle budget |

## Verification
The hardest case to reach is an interrupt that arrives while a command is held by a stalled pipeline. The switch must wait for exactly that one command and no more. The bench first stalls `cmd_ready` with the owner still holding work, then pulses the interrupt, then releases `cmd_ready` for a single cycle. It then checks that exactly one read-pointer advance happened before ownership moved. Overrun is reached by slowing the memory acknowledge enough that a save plus restore exceeds a reduced budget. A fast switch afterwards shows that the flag clears.

// File: rtl/ctx_sched_pkg.sv
// Shared types for the multi-context command scheduler.
// Assumes: context state words are 32 bits wide.
package ctx_sched_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_RUN     = 3'd2,
        ST_SAVE    = 3'd3,
        ST_RESTORE = 3'd4
    } sched_st_e;
endpackage

// File: rtl/ctx_rr_pick.sv
// Round-robin selector: returns the first requesting index strictly after
// `base`, wrapping, with `base` itself considered last.
// Assumes: purely combinational; N >= 2.
module ctx_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] base,
    output logic          found,
    output logic [TW-1:0] pick
);
    // Scan from farthest to nearest so the nearest request wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int off = N; off >= 1; off--) begin
            int idx;
            idx = (int'(base) + off) % N;
            if (req[idx]) begin
                found = 1'b1;
                pick  = TW'(idx);
            end
        end
    end
endmodule

// File: rtl/ctx_mover.sv
// Context word mover: while `go` is high it walks CTX_WORDS words, one per
// memory acknowledge, saving pipeline state (save=1) or restoring it (save=0).
// Assumes: `save` and `thr` are stable while a pass runs; memory acks one
// word per ack, and the word index restarts at 0 after the last ack.
module ctx_mover import ctx_sched_pkg::*; #(
    parameter int CTX_WORDS = 8,
    parameter int TW        = 2,
    parameter int IW        = 3,
    parameter int AW        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              save,
    input  logic [TW-1:0]     thr,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [IW-1:0]     ctx_rd_idx,
    input  logic [WORD_W-1:0] ctx_rd_data,
    output logic              ctx_wr_en,
    output logic [IW-1:0]     ctx_wr_idx,
    output logic [WORD_W-1:0] ctx_wr_data
);
    logic [IW-1:0] idx_q;
    logic          last;

    assign last = (idx_q == IW'(CTX_WORDS - 1));
    assign done = go && mem_ack && last;

    // Word index: advances on each acknowledge, restarts after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            idx_q <= '0;
        end else if (mem_ack) begin
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

    assign mem_req     = go;
    assign mem_we      = go && save;
    assign mem_addr    = AW'(thr) * AW'(CTX_WORDS) + AW'(idx_q);
    assign mem_wdata   = ctx_rd_data;
    assign ctx_rd_idx  = idx_q;
    assign ctx_wr_en   = go && !save && mem_ack;
    assign ctx_wr_idx  = idx_q;
    assign ctx_wr_data = mem_rdata;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (int'(ctx_rd_idx) < CTX_WORDS)); // R6
endmodule

// File: rtl/ctx_sw_timer.sv
// Switch budget timer: counts cycles of an ongoing switch and raises a
// sticky overrun flag once BUDGET cycles have elapsed; the next switch clears it.
// Assumes: `active` is high for exactly the cycles of one switch; BUDGET >= 1.
module ctx_sw_timer #(
    parameter int BUDGET = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic overrun
);
    localparam int CW = $clog2(BUDGET + 1);
    logic [CW-1:0] cnt_q;

    // Elapsed-cycle counter, saturating at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(BUDGET)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Overrun flag: cleared as a switch starts, set when the budget is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (active && cnt_q == '0) begin
            overrun <= 1'b0;
        end else if (active && cnt_q == CW'(BUDGET)) begin
            overrun <= 1'b1;
        end
    end

    AST_OVR_RISE_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(active)); // R11
endmodule

// File: rtl/ctx_sched.sv
// Multi-context command scheduler (top). Watches every thread's command
// descriptor, lets one owner issue commands, and moves ownership through a
// full save/restore of the pipeline state words via one memory port.
// Assumes: only this block advances read pointers (via rd_adv); the memory
// and pipeline state live outside; irq_req is a one-cycle pulse.
module ctx_sched import ctx_sched_pkg::*; #(
    parameter int N_THREADS            = 4,
    parameter int CTX_WORDS            = 8,
    parameter int PTR_W                = 8,
    parameter int SWITCH_BUDGET_CYCLES = 1500,
    localparam int TW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int IW = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1,
    localparam int AW = $clog2(N_THREADS * CTX_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_THREADS-1:0]       desc_valid,
    input  logic [N_THREADS*PTR_W-1:0] desc_rd_ptr,
    input  logic [N_THREADS*PTR_W-1:0] desc_wr_ptr,
    output logic [N_THREADS-1:0]       rd_adv,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [TW-1:0]              cmd_thread,
    output logic [PTR_W-1:0]           cmd_addr,
    input  logic                       irq_req,
    input  logic [TW-1:0]              irq_thread,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [WORD_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic [IW-1:0]              ctx_rd_idx,
    input  logic [WORD_W-1:0]          ctx_rd_data,
    output logic                       ctx_wr_en,
    output logic [IW-1:0]              ctx_wr_idx,
    output logic [WORD_W-1:0]          ctx_wr_data,
    output logic                       owner_valid,
    output logic [TW-1:0]              owner_thread,
    output logic                       switching,
    output logic                       overrun
);
    sched_st_e            st_q, st_d;
    logic [TW-1:0]        act_q, act_d, nxt_q, nxt_d, irq_tgt_q;
    logic                 own_q, own_d, irq_q, irq_clr, hold_q;
    logic [N_THREADS-1:0] pend;
    logic                 rr_found, irq_other, cmd_fire, mv_go, mv_save, mv_done;
    logic [TW-1:0]        rr_pick, rr_base, mv_thr;

    // Per-thread pending-work detection.
    for (genvar t = 0; t < N_THREADS; t++) begin : g_pend
        assign pend[t] = desc_valid[t] &&
                         (desc_rd_ptr[t*PTR_W +: PTR_W] != desc_wr_ptr[t*PTR_W +: PTR_W]);
        assign rd_adv[t] = cmd_fire && (act_q == TW'(t));
    end

    assign rr_base = own_q ? act_q : TW'(N_THREADS - 1);

    ctx_rr_pick #(.N(N_THREADS), .TW(TW)) u_pick (
        .req   (pend),
        .base  (rr_base),
        .found (rr_found),
        .pick  (rr_pick)
    );

    assign irq_other  = irq_q && (!own_q || irq_tgt_q != act_q);
    assign cmd_valid  = (st_q == ST_RUN) && pend[act_q] && (!irq_other || hold_q);
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign cmd_thread = act_q;
    assign cmd_addr   = desc_rd_ptr[int'(act_q)*PTR_W +: PTR_W];

    // Next-state and next-owner selection.
    always_comb begin
        st_d    = st_q;
        nxt_d   = nxt_q;
        act_d   = act_q;
        own_d   = own_q;
        irq_clr = 1'b0;
        case (st_q)
            ST_IDLE: st_d = ST_SCAN;
            ST_SCAN: begin
                if (irq_q) begin
                    nxt_d   = irq_tgt_q;
                    irq_clr = 1'b1;
                    st_d    = ST_RESTORE;
                end else if (rr_found) begin
                    nxt_d = rr_pick;
                    st_d  = ST_RESTORE;
                end
            end
            ST_RUN: begin
                if (irq_q && !irq_other) begin
                    irq_clr = 1'b1;
                end else if (irq_other && !hold_q) begin
                    nxt_d   = irq_tgt_q;
                    irq_clr = 1'b1;
                    st_d    = ST_SAVE;
                end else if (!irq_other && !pend[act_q] && rr_found) begin
                    nxt_d = rr_pick;
                    st_d  = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (mv_done) st_d = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (mv_done) begin
                    st_d  = ST_RUN;
                    act_d = nxt_q;
                    own_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Scheduler state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            act_q  <= '0;
            nxt_q  <= '0;
            own_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            act_q  <= act_d;
            nxt_q  <= nxt_d;
            own_q  <= own_d;
            hold_q <= cmd_valid && !cmd_ready;
        end
    end

    // Interrupt latch: a new request overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            irq_tgt_q <= '0;
        end else begin
            if (irq_clr) irq_q <= 1'b0;
            if (irq_req) begin
                irq_q     <= 1'b1;
                irq_tgt_q <= irq_thread;
            end
        end
    end

    assign mv_go   = (st_q == ST_SAVE) || (st_q == ST_RESTORE);
    assign mv_save = (st_q == ST_SAVE);
    assign mv_thr  = mv_save ? act_q : nxt_q;

    ctx_mover #(.CTX_WORDS(CTX_WORDS), .TW(TW), .IW(IW), .AW(AW)) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (mv_go),
        .save        (mv_save),
        .thr         (mv_thr),
        .done        (mv_done),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .ctx_rd_idx  (ctx_rd_idx),
        .ctx_rd_data (ctx_rd_data),
        .ctx_wr_en   (ctx_wr_en),
        .ctx_wr_idx  (ctx_wr_idx),
        .ctx_wr_data (ctx_wr_data)
    );

    ctx_sw_timer #(.BUDGET(SWITCH_BUDGET_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (mv_go),
        .overrun (overrun)
    );

    assign switching    = mv_go;
    assign owner_valid  = own_q;
    assign owner_thread = act_q;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_thread))); // R4
    AST_NO_CMD_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_valid); // R9
    AST_ADV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_adv)); // R3
    AST_OWNER_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> ((st_q != ST_RUN) || $stable(owner_thread))); // R3
    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rr_found |-> desc_valid[rr_pick]); // R12
endmodule

// File: tb/ctx_sched_tb.sv
// Directed bench for ctx_sched: descriptor, memory and pipeline-state models.
module ctx_sched_tb;
    localparam int N = 4, W = 4, PW = 8, BUD = 20, TW = 2, IW = 2, AW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [N-1:0]      vld = '0;
    logic [PW-1:0]     rd [N];
    logic [PW-1:0]     wr [N];
    logic [N*PW-1:0]   rd_flat, wr_flat;
    logic [N-1:0]      rd_adv;
    logic              cmd_valid, cmd_ready = 1'b0;
    logic [TW-1:0]     cmd_thread;
    logic [PW-1:0]     cmd_addr;
    logic              irq_req = 1'b0;
    logic [TW-1:0]     irq_thread = '0;
    logic              mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [31:0]       mem_wdata, mem_rdata = '0;
    logic [IW-1:0]     ctx_rd_idx, ctx_wr_idx;
    logic [31:0]       ctx_rd_data, ctx_wr_data;
    logic              ctx_wr_en, owner_valid, switching, overrun;
    logic [TW-1:0]     owner_thread;

    logic [31:0] mem  [N*W];
    logic [31:0] pipe [W];
    int          lat = 0, wcnt = 0;
    logic        mark_go = 1'b0;
    int          mark_tag = 0;
    int          n_chk = 0, n_err = 0, mon_err = 0, memreq_cnt = 0;
    logic        prev_wait = 1'b0, prev_we = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    bit          done = 0;

    initial for (int t = 0; t < N; t++) wr[t] = '0;

    always_comb begin
        for (int t = 0; t < N; t++) begin
            rd_flat[t*PW +: PW] = rd[t];
            wr_flat[t*PW +: PW] = wr[t];
        end
    end

    assign ctx_rd_data = pipe[ctx_rd_idx];

    ctx_sched #(.N_THREADS(N), .CTX_WORDS(W), .PTR_W(PW), .SWITCH_BUDGET_CYCLES(BUD)) u_dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(vld), .desc_rd_ptr(rd_flat),
        .desc_wr_ptr(wr_flat), .rd_adv(rd_adv), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_thread(cmd_thread), .cmd_addr(cmd_addr),
        .irq_req(irq_req), .irq_thread(irq_thread), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ctx_rd_idx(ctx_rd_idx),
        .ctx_rd_data(ctx_rd_data), .ctx_wr_en(ctx_wr_en), .ctx_wr_idx(ctx_wr_idx),
        .ctx_wr_data(ctx_wr_data), .owner_valid(owner_valid),
        .owner_thread(owner_thread), .switching(switching), .overrun(overrun)
    );

    function automatic logic [31:0] pat(int t, int i);
        return 32'h5A00_0000 | (t << 8) | i;
    endfunction
    function automatic logic [31:0] mrk(int t, int i);
        return 32'hA5A5_0080 | (t << 8) | i;
    endfunction

    // Models: read pointers, memory contents, pipeline state.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N; t++) rd[t] <= '0;
            for (int t = 0; t < N; t++)
                for (int i = 0; i < W; i++) mem[t*W+i] <= pat(t, i);
            for (int i = 0; i < W; i++) pipe[i] <= '0;
        end else begin
            for (int t = 0; t < N; t++) if (rd_adv[t]) rd[t] <= rd[t] + 1'b1;
            if (mem_req && mem_ack && mem_we) mem[mem_addr] <= mem_wdata;
            if (mark_go) begin
                for (int i = 0; i < W; i++) pipe[i] <= mrk(mark_tag, i);
            end else if (ctx_wr_en) begin
                pipe[ctx_wr_idx] <= ctx_wr_data;
            end
        end
    end

    // Memory responder with programmable wait cycles per word.
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr];
            wcnt = 0;
        end else begin
            mem_ack = 1'b0;
            wcnt++;
        end
    end

    // Continuous protocol monitors (R3, R8, R9).
    always @(posedge clk) begin
        if (rst_n) begin
            logic [N-1:0] exp_adv;
            exp_adv = (cmd_valid && cmd_ready) ? (N'(1) << cmd_thread) : '0;
            if (rd_adv !== exp_adv) begin
                mon_err++;
                $display("FAIL R3 rd_adv actual %h expected %h", rd_adv, exp_adv);
            end
            if (cmd_valid && cmd_thread !== owner_thread) begin
                mon_err++;
                $display("FAIL R3 cmd_thread actual %0d expected %0d", cmd_thread, owner_thread);
            end
            if (cmd_valid && (switching || mem_req)) begin
                mon_err++;
                $display("FAIL R9 cmd_valid actual 1 expected 0 during switch");
            end
            if (prev_wait && (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we)) begin
                mon_err++;
                $display("FAIL R8 mem_addr actual %h expected %h", mem_addr, prev_addr);
            end
            prev_wait = mem_req && !mem_ack;
            prev_addr = mem_addr;
            prev_we   = mem_we;
            if (mem_req) memreq_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_own(input int t, output bit ok);
        ok = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (owner_valid && !switching && owner_thread == TW'(t)) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic do_mark(input int t);
        @(negedge clk);
        mark_tag = t;
        mark_go  = 1'b1;
        @(negedge clk);
        mark_go  = 1'b0;
    endtask

    task automatic pulse_irq(input int t);
        @(negedge clk);
        irq_thread = TW'(t);
        irq_req    = 1'b1;
        @(negedge clk);
        irq_req    = 1'b0;
    endtask

    task automatic check_pipe(input int t, input string tag);
        for (int i = 0; i < W; i++) chk(pipe[i] == pat(t, i), tag, pipe[i], pat(t, i));
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk(!owner_valid && !cmd_valid && !mem_req && rd_adv == '0 && !switching && !overrun,
            "R1 reset outputs", {owner_valid, cmd_valid, mem_req, switching, overrun}, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_first_grant();
        bit ok;
        vld = 4'b0110; wr[0] = 8'd3; wr[1] = 8'd2; wr[2] = 8'd1;
        wait_own(1, ok);
        chk(ok && owner_thread == 2'd1, "R2 R12 first owner", 32'(owner_thread), 32'd1);
        check_pipe(1, "R7 first restore");
        chk(cmd_valid && cmd_addr == 8'd0, "R3 cmd offered by owner", 32'(cmd_addr), 32'd0);
        repeat (3) @(negedge clk);
        chk(cmd_valid && cmd_addr == 8'd0 && rd[1] == 8'd0, "R4 cmd held", 32'(rd[1]), 32'd0);
    endtask

    task automatic t_drain_switch();
        bit ok;
        int c0;
        do_mark(1);
        cmd_ready = 1'b1;
        wait_own(2, ok);
        chk(ok, "R5 switch to next pending", 32'(owner_thread), 32'd2);
        for (int i = 0; i < W; i++) chk(mem[W+i] == mrk(1, i), "R6 save words", mem[W+i], mrk(1, i));
        check_pipe(2, "R7 restore words");
        chk(rd[1] == 8'd2, "R3 advances counted", 32'(rd[1]), 32'd2);
        c0 = memreq_cnt;
        repeat (20) @(negedge clk);
        chk(owner_thread == 2'd2 && memreq_cnt == c0, "R5 owner kept, no traffic", 32'(memreq_cnt - c0), 32'd0);
        chk(rd[2] == 8'd1 && owner_thread != 2'd0, "R12 invalid thread skipped", 32'(owner_thread), 32'd2);
    endtask

    task automatic t_wrap();
        bit ok;
        cmd_ready = 1'b0;
        @(negedge clk);
        wr[0] = 8'd1; wr[3] = 8'd1; vld = 4'b1111;
        wait_own(3, ok);
        chk(ok, "R5 round-robin picks 3 after 2", 32'(owner_thread), 32'd3);
        for (int i = 0; i < W; i++) chk(mem[2*W+i] == pat(2, i), "R6 save of thread 2", mem[2*W+i], pat(2, i));
        cmd_ready = 1'b1;
        wait_own(0, ok);
        chk(ok, "R5 wrap to thread 0", 32'(owner_thread), 32'd0);
        repeat (3) @(negedge clk);
        chk(rd[0] == 8'd1 && rd[3] == 8'd1, "R3 wrap drain", 32'(rd[0]), 32'd1);
    endtask

    task automatic t_irq();
        bit ok;
        int c0;
        cmd_ready = 1'b0;
        c0 = memreq_cnt;
        pulse_irq(0);
        repeat (10) @(negedge clk);
        chk(owner_thread == 2'd0 && memreq_cnt == c0, "R10 irq to owner ignored", 32'(memreq_cnt - c0), 32'd0);
        wr[0] = 8'd5;
        @(negedge clk);
        pulse_irq(2);
        repeat (4) @(negedge clk);
        chk(owner_thread == 2'd0 && !switching && cmd_valid, "R10 waits for in-flight command",
            32'(switching), 32'd0);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        wait_own(2, ok);
        chk(ok, "R10 preempt to target", 32'(owner_thread), 32'd2);
        chk(rd[0] == 8'd2, "R10 exactly one command completed", 32'(rd[0]), 32'd2);
        wait_own(0, ok);
        chk(ok, "R5 return to pending thread 0", 32'(owner_thread), 32'd0);
    endtask

    task automatic t_overrun();
        bit ok;
        chk(!overrun, "R11 no overrun on fast switches", 32'(overrun), 32'd0);
        lat = 3;
        wr[1] = rd[1] + 8'd1;
        pulse_irq(1);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        wait_own(1, ok);
        chk(ok && overrun, "R11 slow switch overruns", 32'(overrun), 32'd1);
        lat = 0;
        cmd_ready = 1'b1;
        wait_own(0, ok);
        chk(ok && !overrun, "R11 cleared by next fast switch", 32'(overrun), 32'd0);
    endtask

    initial begin
        t_reset();
        t_first_grant();
        t_drain_switch();
        t_wrap();
        t_irq();
        t_overrun();
        n_chk += 4;
        n_err += mon_err;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err += mon_err + 1;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule